// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets two processors signal each other through a small register window. Each side has its own simple register port: request, write enable, byte address, write data, a secure qualifier and registered read data. There are three fixed channels. For each channel the block holds two 32-bit status words, one for each direction. A sender raises bits in the word that points toward its partner. The partner gets a one-cycle interrupt pulse, reads the status, and acknowledges by writing the value it read back into the clear register. The sender learns that the transfer is done when its own view of the same word reads as zero.

Each port sees a receive register set and a transmit register set per channel. A set is three words: SET, STAT and CLR. The transmit view of one port and the receive view of the other port map to the same status storage. Channel 2 is reserved for secure accesses.

Every status word is tracked by a two-state machine. EMPTY means the word is all zero. PENDING means at least one bit is raised. The EMPTY to PENDING transition happens at the edge where the word's next value becomes nonzero, and it emits the interrupt pulse. The PENDING to EMPTY transition happens when clears leave the word at zero. In every other case the machine stays in its current state.

Top module: `mbox_regs`

## Requirements
- R1: After reset every status word is zero, both read data outputs are zero and no interrupt output is high.
- R2: Addresses are byte offsets and bits 1:0 are ignored. The receive set of channel c starts at c*0x0C and the transmit set of channel c starts at c*0x0C+0x24. Within a set, SET is at +0x0, STAT is at +0x4 and CLR is at +0x8.
- R3: A write to SET ORs the written bits into the status word. A write to CLR clears each bit written as 1 and leaves the other bits unchanged.
- R4: Port A's transmit set and port B's receive set of the same channel share one status word. Port B's transmit set and port A's receive set share the other word.
- R5: Reads of SET or CLR, and reads at offsets 0x48 and above, return zero. Writes there change nothing.
- R6: The read data of a STAT read appears on the port's rdata one clock after the request edge. It shows the status before any write made at that same edge. In a cycle after which no read was accepted, rdata is zero.
- R7: The receiving side's interrupt for a channel (b_irq for A-to-B words, a_irq for B-to-A words) is high for exactly one cycle after an edge that takes the word from zero to nonzero. It does not pulse when bits are added to a word that is already nonzero.
- R8: When a SET and a CLR hit the same bit at the same edge, from either port, the bit ends up set.
- R9: For channel 2, an access with secure low reads as zero and its writes are ignored. An access with secure high works like any other channel.
- R10: After the receiver writes the STAT value it read into its CLR, the sender's transmit STAT for that channel reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A byte address |
| a_wdata | input | DATA_W | Port A write data |
| a_secure | input | 1 | Port A access is secure |
| a_rdata | output | DATA_W | Port A read data, one cycle after the request |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B byte address |
| b_wdata | input | DATA_W | Port B write data |
| b_secure | input | 1 | Port B access is secure |
| b_rdata | output | DATA_W | Port B read data, one cycle after the request |
| a_irq | output | NUM_CH | Per-channel receive pulse toward processor A |
| b_irq | output | NUM_CH | Per-channel receive pulse toward processor B |

## Verification
Every result is due exactly one clock after the edge that accepts the request. This holds for the read data, the status update and the interrupt pulse, because each passes through one register. The bench applies every vector at a falling edge. It computes the read data and interrupts it expects from its own model of the six status words, using the values held before that vector. It compares them at the next falling edge, so each comparison falls half a period after the edge that produced it. Every vector also checks both rdata outputs and both interrupt vectors, so a spurious pulse or stale read data in an idle cycle is caught as well.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int REGS_PER_SET = 3;

    typedef enum logic [1:0] {
        REG_SET  = 2'd0,
        REG_STAT = 2'd1,
        REG_CLR  = 2'd2
    } mbox_reg_e;

    typedef enum logic {
        SLOT_EMPTY   = 1'b0,
        SLOT_PENDING = 1'b1
    } slot_state_e;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 7,
    parameter int CH_W   = 2
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              secure,
    output logic              hit,
    output logic [CH_W-1:0]   ch,
    output logic              is_tx,
    output mbox_reg_e         kind
);

    localparam int SET_WORDS = REGS_PER_SET * NUM_CH;

    logic        unused_lsb;
    int unsigned word_idx;
    int unsigned rel_idx;

    assign unused_lsb = ^addr[1:0];

    // Word index -> (view, channel, register kind); channel NUM_CH-1 needs secure.
    always_comb begin
        word_idx = 32'(addr[ADDR_W-1:2]);
        is_tx    = (word_idx >= 32'(SET_WORDS));
        rel_idx  = is_tx ? (word_idx - 32'(SET_WORDS)) : word_idx;
        hit      = 1'b0;
        ch       = '0;
        kind     = REG_SET;
        for (int c = 0; c < NUM_CH; c++) begin
            if ((rel_idx >= 32'(c * REGS_PER_SET)) &&
                (rel_idx <  32'((c + 1) * REGS_PER_SET))) begin
                ch   = CH_W'(c);
                kind = mbox_reg_e'(2'(rel_idx - 32'(c * REGS_PER_SET)));
                hit  = req && ((c != NUM_CH - 1) || secure);
            end
        end
    end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] stat,
    output logic              irq_pulse
);

    slot_state_e       state_q;
    slot_state_e       state_d;
    logic [DATA_W-1:0] stat_d;
    logic              irq_d;

    // Set takes priority over clear on the same bit.
    assign stat_d = (stat & ~clr_bits) | set_bits;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY:   if (stat_d != '0) state_d = SLOT_PENDING;
            SLOT_PENDING: if (stat_d == '0) state_d = SLOT_EMPTY;
        endcase
    end

    assign irq_d = (state_q == SLOT_EMPTY) && (state_d == SLOT_PENDING);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat      <= '0;
            irq_pulse <= 1'b0;
        end else begin
            stat      <= stat_d;
            irq_pulse <= irq_d;
        end
    end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_secure,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_secure,
    output logic [DATA_W-1:0] b_rdata,
    output logic [NUM_CH-1:0] a_irq,
    output logic [NUM_CH-1:0] b_irq
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              a_hit, b_hit;
    logic [CH_W-1:0]   a_ch, b_ch;
    logic              a_tx, b_tx;
    mbox_reg_e         a_kind, b_kind;
    logic [DATA_W-1:0] a2b_stat [NUM_CH];
    logic [DATA_W-1:0] b2a_stat [NUM_CH];
    logic [DATA_W-1:0] a_rd_d, b_rd_d;

    mbox_port_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec_a (
        .req(a_req), .addr(a_addr), .secure(a_secure),
        .hit(a_hit), .ch(a_ch), .is_tx(a_tx), .kind(a_kind)
    );

    mbox_port_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec_b (
        .req(b_req), .addr(b_addr), .secure(b_secure),
        .hit(b_hit), .ch(b_ch), .is_tx(b_tx), .kind(b_kind)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              a_sel, b_sel;
        logic [DATA_W-1:0] a2b_set, a2b_clr, b2a_set, b2a_clr;

        assign a_sel = a_hit && a_we && (a_ch == CH_W'(c));
        assign b_sel = b_hit && b_we && (b_ch == CH_W'(c));

        // A-to-B word: A's transmit view, B's receive view.
        assign a2b_set = ((a_sel &&  a_tx && a_kind == REG_SET) ? a_wdata : '0)
                       | ((b_sel && !b_tx && b_kind == REG_SET) ? b_wdata : '0);
        assign a2b_clr = ((a_sel &&  a_tx && a_kind == REG_CLR) ? a_wdata : '0)
                       | ((b_sel && !b_tx && b_kind == REG_CLR) ? b_wdata : '0);
        // B-to-A word: B's transmit view, A's receive view.
        assign b2a_set = ((b_sel &&  b_tx && b_kind == REG_SET) ? b_wdata : '0)
                       | ((a_sel && !a_tx && a_kind == REG_SET) ? a_wdata : '0);
        assign b2a_clr = ((b_sel &&  b_tx && b_kind == REG_CLR) ? b_wdata : '0)
                       | ((a_sel && !a_tx && a_kind == REG_CLR) ? a_wdata : '0);

        mbox_slot #(.DATA_W(DATA_W)) u_a2b (
            .clk(clk), .rst_n(rst_n), .set_bits(a2b_set), .clr_bits(a2b_clr),
            .stat(a2b_stat[c]), .irq_pulse(b_irq[c])
        );

        mbox_slot #(.DATA_W(DATA_W)) u_b2a (
            .clk(clk), .rst_n(rst_n), .set_bits(b2a_set), .clr_bits(b2a_clr),
            .stat(b2a_stat[c]), .irq_pulse(a_irq[c])
        );
    end

    always_comb begin
        a_rd_d = '0;
        b_rd_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (a_hit && !a_we && a_kind == REG_STAT && a_ch == CH_W'(c)) begin
                a_rd_d = a_tx ? a2b_stat[c] : b2a_stat[c];
            end
            if (b_hit && !b_we && b_kind == REG_STAT && b_ch == CH_W'(c)) begin
                b_rd_d = b_tx ? b2a_stat[c] : a2b_stat[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            a_rdata <= a_rd_d;
            b_rdata <= b_rd_d;
        end
    end

endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_req,
    input logic              a_we,
    input logic              a_secure,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_wdata,
    input logic [DATA_W-1:0] a_rdata,
    input logic              b_req,
    input logic [NUM_CH-1:0] a_irq,
    input logic [NUM_CH-1:0] b_irq,
    input logic [DATA_W-1:0] a2b_stat [NUM_CH],
    input logic [DATA_W-1:0] b2a_stat [NUM_CH]
);

    localparam int SET_WORDS = REGS_PER_SET * NUM_CH;
    localparam int LAST      = NUM_CH - 1;
    localparam int WW        = ADDR_W - 2;

    logic [WW-1:0] a_word;
    logic          unused_chk;
    logic          a_in_last;

    assign a_word     = a_addr[ADDR_W-1:2];
    assign unused_chk = ^a_addr[1:0];
    assign a_in_last  = ((a_word >= WW'(REGS_PER_SET * LAST)) &&
                         (a_word <  WW'(REGS_PER_SET * LAST + REGS_PER_SET))) ||
                        ((a_word >= WW'(SET_WORDS + REGS_PER_SET * LAST)) &&
                         (a_word <  WW'(SET_WORDS + REGS_PER_SET * LAST + REGS_PER_SET)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
        AST_B_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            b_irq[c] |=> !b_irq[c]); // R7
        AST_A_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            a_irq[c] |=> !a_irq[c]); // R7
        AST_B_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            b_irq[c] |-> (a2b_stat[c] != '0) && ($past(a2b_stat[c]) == '0)); // R7
        AST_A_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            a_irq[c] |-> (b2a_stat[c] != '0) && ($past(b2a_stat[c]) == '0)); // R7
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_we && a_secure && a_word == WW'(SET_WORDS))
        |=> ((a2b_stat[0] & $past(a_wdata)) == $past(a_wdata))); // R8

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_we && a_word >= WW'(2 * SET_WORDS)) |=> (a_rdata == '0)); // R5

    AST_NS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_we && !a_secure && a_in_last) |=> (a_rdata == '0)); // R9

    AST_NS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_we && !a_secure && a_word == WW'(SET_WORDS + REGS_PER_SET * LAST) && !b_req)
        |=> $stable(a2b_stat[LAST])); // R9

endmodule

bind mbox_regs mbox_regs_chk #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/mbox_regs_tb_top.sv
`timescale 1ns/1ps
module mbox_regs_tb_top;

    localparam int NCH = 3;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 0, a_we = 0, a_secure = 0;
    logic [6:0]  a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic        b_req = 0, b_we = 0, b_secure = 0;
    logic [6:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [NCH-1:0] a_irq, b_irq;

    int n_vec = 0;
    int n_err = 0;
    bit done = 0;

    // Model: slot 0 = A-to-B word, slot 1 = B-to-A word.
    logic [31:0] m_stat [2][NCH];
    logic [31:0] m_set  [2][NCH];
    logic [31:0] m_clr  [2][NCH];

    always #10 clk = ~clk;

    mbox_regs #(.NUM_CH(NCH), .DATA_W(32), .ADDR_W(7)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_secure(a_secure), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_secure(b_secure), .b_rdata(b_rdata),
        .a_irq(a_irq), .b_irq(b_irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Expected effect of one port access, from the address map of R2/R4/R5/R9.
    function automatic void port_eff(input int port, input bit r, input bit w,
                                     input logic [6:0] ad, input logic [31:0] wd,
                                     input bit sec, output logic [31:0] rd);
        int word, rel, ch, kind, slot;
        bit tx, ok;
        word = int'(ad[6:2]);
        tx   = (word >= 3 * NCH);
        rel  = tx ? word - 3 * NCH : word;
        ok   = 0;
        ch   = 0;
        kind = 0;
        rd   = '0;
        if (rel < 3 * NCH) begin
            ch   = rel / 3;
            kind = rel % 3;
            ok   = r && ((ch != NCH - 1) || sec);
        end
        if (ok) begin
            slot = (port == int'(tx)) ? 1 : 0;
            if (!w && kind == 1) rd = m_stat[slot][ch];
            if (w && kind == 0) m_set[slot][ch] = m_set[slot][ch] | wd;
            if (w && kind == 2) m_clr[slot][ch] = m_clr[slot][ch] | wd;
        end
    endfunction

    task automatic step(input string tag,
                        input bit ar, input bit aw, input logic [6:0] aad,
                        input logic [31:0] awd, input bit as,
                        input bit br, input bit bw, input logic [6:0] bad,
                        input logic [31:0] bwd, input bit bs);
        logic [31:0] ea, eb, nv;
        logic [NCH-1:0] eia, eib;
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < NCH; c++) begin
                m_set[s][c] = '0;
                m_clr[s][c] = '0;
            end
        port_eff(0, ar, aw, aad, awd, as, ea);
        port_eff(1, br, bw, bad, bwd, bs, eb);
        for (int c = 0; c < NCH; c++) begin
            nv = (m_stat[0][c] & ~m_clr[0][c]) | m_set[0][c];
            eib[c] = (m_stat[0][c] == 0) && (nv != 0);
            m_stat[0][c] = nv;
            nv = (m_stat[1][c] & ~m_clr[1][c]) | m_set[1][c];
            eia[c] = (m_stat[1][c] == 0) && (nv != 0);
            m_stat[1][c] = nv;
        end
        a_req = ar; a_we = aw; a_addr = aad; a_wdata = awd; a_secure = as;
        b_req = br; b_we = bw; b_addr = bad; b_wdata = bwd; b_secure = bs;
        @(negedge clk);
        check(tag, "a_rdata", a_rdata, ea);
        check(tag, "b_rdata", b_rdata, eb);
        check("R7", "a_irq", 32'(a_irq), 32'(eia));
        check("R7", "b_irq", 32'(b_irq), 32'(eib));
    endtask

    task automatic wr_a(input string t, input logic [6:0] ad, input logic [31:0] d, input bit s = 1);
        step(t, 1, 1, ad, d, s, 0, 0, '0, '0, 0);
    endtask
    task automatic rd_a(input string t, input logic [6:0] ad, input bit s = 1);
        step(t, 1, 0, ad, '0, s, 0, 0, '0, '0, 0);
    endtask
    task automatic wr_b(input string t, input logic [6:0] ad, input logic [31:0] d, input bit s = 1);
        step(t, 0, 0, '0, '0, 0, 1, 1, ad, d, s);
    endtask
    task automatic rd_b(input string t, input logic [6:0] ad, input bit s = 1);
        step(t, 0, 0, '0, '0, 0, 1, 0, ad, '0, s);
    endtask

    initial begin
        #(MAX_CYCLES * 20);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd_val;
        void'($urandom(32'd715));
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < NCH; c++) m_stat[s][c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "a_rdata", a_rdata, '0);
        check("R1", "b_rdata", b_rdata, '0);
        check("R1", "a_irq", 32'(a_irq), '0);
        check("R1", "b_irq", 32'(b_irq), '0);
        for (int c = 0; c < NCH; c++) begin
            rd_a("R1", 7'(12 * c + 4));
            rd_a("R1", 7'(12 * c + 8'h28));
            rd_b("R1", 7'(12 * c + 4));
        end

        // R2/R4: A sends on channel 1, B sees it in its receive view.
        wr_a("R4", 7'h30, 32'h0000_00A5);
        rd_b("R2", 7'h10);
        rd_a("R4", 7'h34);
        wr_a("R7", 7'h30, 32'h0000_0100);   // already pending: no new pulse
        rd_b("R2", 7'h10);
        rd_val = b_rdata;
        wr_b("R10", 7'h14, rd_val);         // acknowledge with value read
        rd_a("R10", 7'h34);
        check("R10", "tx stat after ack", a_rdata, 32'h0);
        wr_b("R4", 7'h24, 32'h8000_0001);   // B sends on channel 0
        rd_a("R2", 7'h04);
        check("R4", "B-to-A word", a_rdata, 32'h8000_0001);

        // R3: OR on set, selective clear.
        wr_a("R3", 7'h24, 32'h0000_F0F0);
        wr_a("R3", 7'h24, 32'h0000_0F00);
        wr_b("R3", 7'h08, 32'h0000_F000);
        rd_b("R3", 7'h04);
        check("R3", "or/clear", b_rdata, 32'h0000_0FF0);

        // R5: SET/CLR and out-of-window reads are zero; R6 idle rdata zero.
        rd_a("R5", 7'h24);
        rd_a("R5", 7'h2C);
        rd_a("R5", 7'h48);
        rd_b("R5", 7'h7C);
        wr_a("R5", 7'h4C, 32'hFFFF_FFFF);
        step("R6", 0, 0, '0, '0, 0, 0, 0, '0, '0, 0);

        // R8: set and clear collide on the same bits.
        step("R8", 1, 1, 7'h24, 32'h0000_00FF, 1, 1, 1, 7'h08, 32'hFFFF_FFFF, 1);
        rd_b("R8", 7'h04);
        check("R8", "set wins", b_rdata, 32'h0000_00FF);

        // R9: channel 2 needs secure.
        wr_a("R9", 7'h3C, 32'h0000_0005, 0);
        rd_b("R9", 7'h1C, 1);
        check("R9", "ns write ignored", b_rdata, 32'h0);
        wr_a("R9", 7'h3C, 32'h0000_0005, 1);
        rd_a("R9", 7'h40, 0);
        rd_a("R9", 7'h40, 1);
        wr_b("R9", 7'h20, 32'h0000_0005, 0);
        rd_b("R9", 7'h1C, 1);
        check("R9", "ns clear ignored", b_rdata, 32'h0000_0005);

        // Random mix: R3/R4/R6/R7 against the model.
        for (int i = 0; i < 4000; i++) begin
            bit ar, aw, as, br, bw, bs;
            logic [6:0] aad, bad;
            logic [31:0] awd, bwd;
            ar  = ($urandom_range(0, 9) < 7);
            aw  = $urandom_range(0, 1);
            as  = ($urandom_range(0, 9) < 8);
            aad = {5'($urandom_range(0, 19)), 2'($urandom_range(0, 3))};
            awd = (1 << $urandom_range(0, 31)) | ($urandom_range(0, 3) == 0 ? $urandom : 0);
            br  = ($urandom_range(0, 9) < 7);
            bw  = $urandom_range(0, 1);
            bs  = ($urandom_range(0, 9) < 8);
            bad = {5'($urandom_range(0, 19)), 2'($urandom_range(0, 3))};
            bwd = ($urandom_range(0, 2) == 0) ? 32'hFFFF_FFFF : $urandom;
            step("R3/R4/R6", ar, aw, aad, awd, as, br, bw, bad, bwd, bs);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule